// File: doc/BRIEF.md
# Recursive Column-Sum Unsigned Multiplier

This block multiplies two unsigned integers of a configurable width and returns the full double-width product. It is built entirely from one tiny cell: a 2x2-bit multiplier that forms its result column by column. It ANDs the two low bits for the first column. It adds the two cross bit products for the middle column. It adds the carry to the product of the two high bits for the last column. Four such cells, joined by a carry-save merge, make a 4x4 multiplier. Four 4x4 multipliers make an 8x8, and so on up the power-of-two ladder.

An operand width that is not a power of two is zero-extended to the next power of two inside the block. Only the low 2*OP_W product bits are brought out. The default of 24 bits therefore fits the mantissa product of a single-precision floating-point multiplier, and it uses a 32-bit core internally. A parameter chooses between a purely combinational result and one taken through an output register.

Top module: `vc_multiplier`

## Requirements
- R1: Bit 0 of the product equals the AND of bit 0 of both operands.
- R2: The product output equals the exact unsigned product of the two operands, 2*OP_W bits wide, for any operand values. This holds for the default width of 24 and for a width of 32.
- R3: With REG_OUT=1, the product output changes only at a rising clock edge. After that edge it shows the product of the operands sampled at that edge. New operands applied between edges do not disturb it.
- R4: With REG_OUT=1, a rising edge that sees rst_n low clears the product output to zero, whatever the operands are.
- R5: Multiplying any operand by zero gives zero, and multiplying by one gives the other operand unchanged.
- R6: Two all-ones operands give 2^(2N) - 2^(N+1) + 1: bit 0 set, bits 1 to N zero, and bits N+1 to 2N-1 set.
- R7: Single-bit operands 2^i and 2^j give exactly 2^(i+j) for every i and j below OP_W. This covers the placement of low, cross and high partial products at weights 0, half-width and full-width at every level.
- R8: The base cell forms each result column from the bit products whose indices sum to that column, plus the carry of the previous column. A 4-bit instance built from four cells returns the exact product for all 256 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_i | input | OP_W | Unsigned multiplicand |
| b_i | input | OP_W | Unsigned multiplier |
| prod_o | output | 2*OP_W | Unsigned product, registered when REG_OUT=1 |

## Verification
Walking single-bit operands target the placement of partial products. If a cross product were shifted by the wrong weight at any level, or if the two cross products were swapped, a lone set bit would land in the wrong position. All-ones operands drive the longest carry chains through the carry-save merge. A dropped carry bit or a truncated merge width shows up there as a corrupted upper half. The exhaustive 4-bit sweep exposes a base cell whose middle-column carry does not reach the last column, which would give wrong results only when both high bits are set. Reset with live nonzero operands, and operand changes between clock edges, catch a register that passes data through or ignores reset.

// File: rtl/vc_pkg.sv
// Package: shared helpers for the recursive column-sum multiplier.
// Assumes: widths are positive integers; the core is sized to a power of two.
package vc_pkg;

    // Smallest power of two that is at least n and at least 2.
    function automatic int ceil_pow2(input int n);
        int p;
        p = 2;
        while (p < n) p = p * 2;
        return p;
    endfunction

endpackage

// File: rtl/vc_cell2.sv
// vc_cell2: 2x2-bit unsigned multiplier using column sums.
// Column 0 is the AND of the low bits. Column 1 sums both cross products.
// Column 2 adds the column-1 carry to the product of the high bits.
// Assumes: purely combinational, no clock.
module vc_cell2 (
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    output logic [3:0] prod_o
);

    // Form the three column sums and pack the 4-bit result.
    always_comb begin
        logic       col0;
        logic [1:0] col1;
        logic [1:0] col2;
        col0   = a_i[0] & b_i[0];
        col1   = {1'b0, a_i[1] & b_i[0]} + {1'b0, a_i[0] & b_i[1]};
        col2   = {1'b0, col1[1]} + {1'b0, a_i[1] & b_i[1]};
        prod_o = {col2, col1[0], col0};
        assert_cell_exact_R8: assert ({col2, col1[0], col0} == 4'(a_i) * 4'(b_i))
            else $error("2x2 cell result wrong");
    end

endmodule

// File: rtl/vc_merge.sv
// vc_merge: joins four half-width partial products into one W x W product.
// The low-low product sits at weight 0, both cross products at weight W/2,
// and the high-high product at weight W. The three operands go through one
// carry-save level and then one carry-propagate add.
// Assumes: W is even; the inputs are true products of W/2-bit halves.
module vc_merge #(
    parameter int W = 4
) (
    input  logic [W-1:0]   ll_i,
    input  logic [W-1:0]   lh_i,
    input  logic [W-1:0]   hl_i,
    input  logic [W-1:0]   hh_i,
    output logic [2*W-1:0] prod_o
);

    localparam int H  = W / 2;
    localparam int PW = 2 * W;

    logic [PW-1:0] opnd_x;
    logic [PW-1:0] opnd_y;
    logic [PW-1:0] opnd_z;
    logic [PW-1:0] cs_sum;
    logic [PW-2:0] cs_cry;

    // Align the partial products; high-high and low-low never overlap.
    always_comb begin
        opnd_x = {hh_i, ll_i};
        opnd_y = {{H{1'b0}}, lh_i, {H{1'b0}}};
        opnd_z = {{H{1'b0}}, hl_i, {H{1'b0}}};
    end

    // One carry-save level reducing three operands to sum and carry.
    always_comb begin
        cs_sum = opnd_x ^ opnd_y ^ opnd_z;
        cs_cry = (opnd_x[PW-2:0] & opnd_y[PW-2:0])
               | (opnd_x[PW-2:0] & opnd_z[PW-2:0])
               | (opnd_y[PW-2:0] & opnd_z[PW-2:0]);
    end

    // Final carry-propagate addition.
    always_comb begin
        prod_o = cs_sum + {cs_cry, 1'b0};
    end

endmodule

// File: rtl/vc_mult_rec.sv
// vc_mult_rec: W x W unsigned multiplier built recursively from four
// half-width multipliers down to the 2x2 cell.
// Assumes: W is a power of two, at least 2.
module vc_mult_rec #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);

    localparam int H = W / 2;

    generate
        if (W == 2) begin : g_leaf
            vc_cell2 u_cell (
                .a_i    (a_i),
                .b_i    (b_i),
                .prod_o (prod_o)
            );
        end else begin : g_node
            logic [W-1:0] pp_ll;
            logic [W-1:0] pp_lh;
            logic [W-1:0] pp_hl;
            logic [W-1:0] pp_hh;

            vc_mult_rec #(.W(H)) u_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .prod_o(pp_ll));
            vc_mult_rec #(.W(H)) u_lh (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .prod_o(pp_lh));
            vc_mult_rec #(.W(H)) u_hl (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .prod_o(pp_hl));
            vc_mult_rec #(.W(H)) u_hh (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .prod_o(pp_hh));

            vc_merge #(.W(W)) u_merge (
                .ll_i   (pp_ll),
                .lh_i   (pp_lh),
                .hl_i   (pp_hl),
                .hh_i   (pp_hh),
                .prod_o (prod_o)
            );
        end
    endgenerate

endmodule

// File: rtl/vc_multiplier.sv
// vc_multiplier: OP_W x OP_W unsigned multiplier with a 2*OP_W result.
// Operands are zero-extended to a power-of-two core and the low 2*OP_W
// product bits are kept. REG_OUT=1 adds an output register with a
// synchronous active-low reset; REG_OUT=0 leaves the path combinational.
// Assumes: OP_W >= 2.
module vc_multiplier
    import vc_pkg::*;
#(
    parameter int OP_W    = 24,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    output logic [2*OP_W-1:0] prod_o
);

    localparam int CORE_W = ceil_pow2(OP_W);
    localparam int PAD_W  = CORE_W - OP_W;
    localparam int PW     = 2 * OP_W;
    localparam int CPW    = 2 * CORE_W;

    logic [CORE_W-1:0] a_ext;
    logic [CORE_W-1:0] b_ext;
    logic [CPW-1:0]    core_prod;

    generate
        if (PAD_W > 0) begin : g_pad
            // Zero-extend both operands into the core width.
            always_comb begin
                a_ext = {{PAD_W{1'b0}}, a_i};
                b_ext = {{PAD_W{1'b0}}, b_i};
            end
            // R2: padded operands must leave the bits above 2*OP_W clear.
            always_comb begin
                assert_pad_clear_R2: assert (core_prod[CPW-1:PW] == '0)
                    else $error("nonzero product bits above result width");
            end
        end else begin : g_nopad
            // Core width equals operand width.
            always_comb begin
                a_ext = a_i;
                b_ext = b_i;
            end
        end
    endgenerate

    vc_mult_rec #(.W(CORE_W)) u_core (
        .a_i    (a_ext),
        .b_i    (b_ext),
        .prod_o (core_prod)
    );

    generate
        if (REG_OUT) begin : g_reg
            // Capture the product each edge; clear it under reset.
            always_ff @(posedge clk) begin
                if (!rst_n) prod_o <= '0;
                else        prod_o <= core_prod[PW-1:0];
            end

            // R2, R3: output equals the product of the operands one edge back.
            assert_reg_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> prod_o == PW'($past(a_i)) * PW'($past(b_i)))
                else $error("registered product mismatch");

            // R1: lowest result bit is the AND of the operand LSBs.
            assert_lsb_and_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> prod_o[0] == ($past(a_i[0]) & $past(b_i[0])))
                else $error("product LSB wrong");

            // R4: the first edge after reset release still shows zero.
            assert_reset_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(rst_n) |-> prod_o == '0)
                else $error("output not cleared by reset");
        end else begin : g_comb
            // Pass the core product straight through.
            always_comb begin
                prod_o = core_prod[PW-1:0];
            end

            // R2: combinational output equals the exact product.
            assert_comb_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
                prod_o == PW'(a_i) * PW'(b_i))
                else $error("combinational product mismatch");
        end
    endgenerate

endmodule

// File: tb/tb_vc_multiplier.sv
// tb_vc_multiplier: directed bench, one task per scenario, each self-checking.
module tb_vc_multiplier;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [23:0] a24 = '0, b24 = '0;
    logic [47:0] p24;
    logic [31:0] a32 = '0, b32 = '0;
    logic [63:0] p32;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    vc_multiplier #(.OP_W(24), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .a_i(a24), .b_i(b24), .prod_o(p24));
    vc_multiplier #(.OP_W(32), .REG_OUT(1'b1)) dut_wide (
        .clk(clk), .rst_n(rst_n), .a_i(a32), .b_i(b32), .prod_o(p32));
    vc_multiplier #(.OP_W(4), .REG_OUT(1'b0)) dut_small (
        .clk(clk), .rst_n(rst_n), .a_i(a4), .b_i(b4), .prod_o(p4));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive 24-bit operands, let one edge pass, check at the next falling edge.
    task automatic run24(input string req, input logic [23:0] a, input logic [23:0] b,
                         input logic [47:0] exp);
        @(negedge clk);
        a24 = a; b24 = b;
        @(negedge clk);
        chk(req, {16'h0, p24}, {16'h0, exp});
    endtask

    task automatic run32(input string req, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        a32 = a; b32 = b;
        @(negedge clk);
        chk(req, p32, 64'(a) * 64'(b));
    endtask

    // R4: reset clears output at time zero and mid-run with live operands.
    task automatic t_reset();
        a24 = 24'h123456; b24 = 24'h00ABCD;
        @(negedge clk); @(negedge clk);
        chk("R4 reset at start", {16'h0, p24}, 64'h0);
        rst_n = 1'b1;
        run24("R2 before mid reset", 24'hFFFFFF, 24'h000003, 48'(24'hFFFFFF) * 48'd3);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R4 reset mid-run", {16'h0, p24}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 after release", {16'h0, p24}, 48'(24'hFFFFFF) * 48'd3);
    endtask

    // R3: operands changing between edges leave the registered output alone.
    task automatic t_register();
        run24("R3 load", 24'd1000, 24'd3000, 48'd3000000);
        @(negedge clk);
        a24 = 24'd7; b24 = 24'd9;
        #1;
        chk("R3 hold between edges", {16'h0, p24}, 64'd3000000);
        @(negedge clk);
        chk("R3 update at edge", {16'h0, p24}, 64'd63);
    endtask

    // R1: LSB is the AND of the operand LSBs.
    task automatic t_lsb();
        for (int k = 0; k < 4; k++) begin
            logic [23:0] a, b;
            a = 24'hA5A5A4 | 24'(k & 1);
            b = 24'h3C3C3C | 24'((k >> 1) & 1);
            run24("R1 lsb", a, b, 48'(a) * 48'(b));
            chk("R1 lsb bit", {63'h0, p24[0]}, {63'h0, a[0] & b[0]});
        end
    endtask

    // R5: zero and one operands.
    task automatic t_zero_one();
        run24("R5 zero times", 24'h000000, 24'hDEADBE, 48'h0);
        run24("R5 times zero", 24'hFFFFFF, 24'h000000, 48'h0);
        run24("R5 one times", 24'h000001, 24'hC0FFEE, 48'h000000C0FFEE);
        run24("R5 times one", 24'h9ABCDE, 24'h000001, 48'h0000009ABCDE);
    endtask

    // R6: all-ones operands give the maximal product.
    task automatic t_max();
        run24("R6 max 24", 24'hFFFFFF, 24'hFFFFFF, 48'hFFFFFE000001);
        run32("R6 max 32", 32'hFFFFFFFF, 32'hFFFFFFFF);
        chk("R6 max 32 value", p32, 64'hFFFFFFFE00000001);
    endtask

    // R7: walking single bits land at weight i+j.
    task automatic t_walk();
        for (int i = 0; i < 24; i++) begin
            for (int j = 0; j < 24; j++) begin
                run24("R7 walking ones", 24'(1) << i, 24'(1) << j, 48'(1) << (i + j));
            end
        end
    endtask

    // R8: exhaustive 4-bit instance built from 2x2 cells.
    task automatic t_small();
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                a4 = 4'(i); b4 = 4'(j);
                #1;
                chk("R8 exhaustive 4-bit", {56'h0, p4}, 64'(i * j));
            end
        end
    endtask

    // R2: random operands at 24 and 32 bits.
    task automatic t_random();
        for (int k = 0; k < 1500; k++) begin
            logic [23:0] a, b;
            a = 24'($urandom); b = 24'($urandom);
            run24("R2 random 24", a, b, 48'(a) * 48'(b));
        end
        for (int k = 0; k < 1500; k++) begin
            run32("R2 random 32", $urandom, $urandom);
        end
    endtask

    initial begin
        t_reset();
        t_register();
        t_lsb();
        t_zero_one();
        t_max();
        t_walk();
        t_small();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_fail++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule